// File: doc/BRIEF.md
# Triggered Pulse Timer with Buffered Compares

This block is a 16-bit up-counter that produces up to three pulse outputs after an external start event. Software sets it up through a small write-only register port. That port carries one control word, which holds a run-enable bit and a tick-source selector, and four compare words. Setting the run-enable bit does not start counting. It puts the timer into a trigger-wait state, and the first rising edge on the trigger input then starts the count from zero. Compare word 0 sets the cycle length. Compare words 1 to 3 set the width of pulse outputs 1 to 3, each measured from the start of every cycle.

Every compare word has a working copy behind it, and only that working copy is used for matching. New compare values move into the working copies at a counter clear, and only when a reload has been armed. Writing compare word 1 is the only way to arm a reload. When several words change, software writes words 0, 2 and 3 first and word 1 last. To change only the duty of outputs 2 and 3, software rewrites word 1 with its current value after writing them.

The register port has no back-pressure: a write is accepted in the cycle its strobe is high, and no ready signal exists. The trigger input and the tick inputs are plain level signals, sampled on the clock.

Top module: `trig_pulse_timer`

## Requirements
- R1: After reset the timer is idle, `count_o` is 0 and all pulse outputs are low.
- R2: A control write (address 0) with bit 0 = 1 while the timer is disabled copies all four compare words into their working copies at once and enters trigger-wait. In trigger-wait, `count_o` stays 0 and the pulses stay low.
- R3: A rising edge on `trig_i` during trigger-wait starts the count: `count_o` is 0 in the following cycle and then rises by one in each cycle in which the selected tick is high.
- R4: Control bits [3:1] choose which bit of `tick_i` advances the counter, and they may be written in the same access that sets the enable bit. A tick on any other bit has no effect on the count.
- R5: When `count_o` equals working compare 0 on a tick, the counter clears to 0, so one cycle lasts compare 0 + 1 ticks.
- R6: While counting, `pulse_o[k-1]` is high exactly when `count_o` is below working compare k, for k = 1, 2, 3.
- R7: Writes to compare words 0, 2 and 3 (addresses 4, 6 and 7) leave the working copies unchanged until a reload is armed and a clear follows.
- R8: A write to compare word 1 (address 5) arms a reload. At the next counter clear, all four working copies load from the compare words and the arm is consumed.
- R9: A rising edge on `trig_i` while counting restarts the count at 0, and this restart counts as a counter clear for any armed reload.
- R10: A control write with bit 0 = 0 stops the timer: `count_o` becomes 0, the pulses go low, and trigger edges are ignored until the timer is enabled again.
- R11: Writes to addresses 1, 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, always accepted |
| wr_addr | input | 3 | Register address: 0 control, 4..7 compare 0..3 |
| wr_data | input | 16 | Write data |
| trig_i | input | 1 | External trigger level, acted on at its rising edge |
| tick_i | input | 8 | Candidate count-enable ticks, one chosen by the select field |
| count_o | output | 16 | Current counter value |
| pulse_o | output | 3 | Pulse outputs 1..3 |

## Verification
The bench writes the compare words in the wrong order to make sure nothing reaches the working copies without an arm. A design that reloaded on any write would change pulse widths one period early. It rewrites word 1 with the same value to confirm that a duty change on outputs 2 and 3 takes effect at the next wrap. It also checks that a new compare 0 changes the cycle length only after the next clear. Further cases cover a retrigger in the middle of a cycle, a gated tick source, writes to unused addresses, and re-enabling with only compare 0 changed. A design that needed an arm on first enable would keep the old cycle length in that last case.

// File: rtl/tpt_pkg.sv
package tpt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } tpt_state_e;

  localparam int CTRL_ADDR = 0;
  localparam int CMP_BASE  = 4;
  localparam int ARM_INDEX = 1;
endpackage

// File: rtl/tpt_ctrl.sv
module tpt_ctrl
  import tpt_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int ADDR_W = 3,
  localparam int SEL_W = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [SEL_W:0]    wr_ctrl_bits,
  input  logic              trig_i,
  input  logic [N_SRC-1:0]  tick_i,
  output tpt_state_e        st_q,
  output logic              tick_sel,
  output logic              trig_edge,
  output logic              start,
  output logic              stop,
  output logic              load_all
);
  logic             en_q;
  logic [SEL_W-1:0] sel_q;
  logic             trig_q;
  logic             ctrl_wr;
  tpt_state_e       st_n;

  assign ctrl_wr   = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
  assign stop      = ctrl_wr && !wr_ctrl_bits[0];
  assign load_all  = ctrl_wr && wr_ctrl_bits[0] && !en_q;
  assign trig_edge = trig_i && !trig_q;
  assign start     = (st_q == ST_WAIT) && trig_edge && !stop;
  assign tick_sel  = tick_i[sel_q];

  always_comb begin
    st_n = st_q;
    if (stop)          st_n = ST_IDLE;
    else if (load_all) st_n = ST_WAIT;
    else if (start)    st_n = ST_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      sel_q  <= '0;
      trig_q <= 1'b0;
      st_q   <= ST_IDLE;
    end else begin
      trig_q <= trig_i;
      st_q   <= st_n;
      if (ctrl_wr) begin
        en_q  <= wr_ctrl_bits[0];
        sel_q <= wr_ctrl_bits[SEL_W:1];
      end
    end
  end
endmodule

// File: rtl/tpt_counter.sv
module tpt_counter
  import tpt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tpt_state_e       st_q,
  input  logic             start,
  input  logic             stop,
  input  logic             trig_edge,
  input  logic             tick_sel,
  input  logic [CNT_W-1:0] period_buf,
  output logic [CNT_W-1:0] cnt_q,
  output logic             clr_ev
);
  logic run_ok;
  logic wrap;
  logic restart;

  assign run_ok  = (st_q == ST_RUN) && !stop;
  assign restart = run_ok && trig_edge;
  assign wrap    = run_ok && tick_sel && (cnt_q == period_buf) && !trig_edge;
  assign clr_ev  = start || restart || wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (stop || clr_ev)   cnt_q <= '0;
    else if (run_ok && tick_sel) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tpt_cmpbuf.sv
module tpt_cmpbuf
  import tpt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int N_CMP  = 4,
  parameter int ADDR_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [CNT_W-1:0]       wr_data,
  input  logic                   load_all,
  input  logic                   clr_ev,
  output logic [N_CMP*CNT_W-1:0] buf_flat,
  output logic                   arm_q,
  output logic                   wr_arm
);
  logic reload;

  assign wr_arm = wr_en && (wr_addr == ADDR_W'(CMP_BASE + ARM_INDEX));
  assign reload = load_all || (clr_ev && arm_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       arm_q <= 1'b0;
    else if (wr_arm)  arm_q <= 1'b1;
    else if (reload)  arm_q <= 1'b0;
  end

  for (genvar m = 0; m < N_CMP; m++) begin : g_cmp
    logic [CNT_W-1:0] shadow_q;
    logic [CNT_W-1:0] work_q;
    logic             hit;

    assign hit = wr_en && (wr_addr == ADDR_W'(CMP_BASE + m));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q <= '0;
        work_q   <= '0;
      end else begin
        if (hit)    shadow_q <= wr_data;
        if (reload) work_q   <= shadow_q;
      end
    end

    assign buf_flat[m*CNT_W +: CNT_W] = work_q;
  end
endmodule

// File: rtl/tpt_outgen.sv
module tpt_outgen
  import tpt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_CMP = 4
) (
  input  tpt_state_e             st_q,
  input  logic [CNT_W-1:0]       cnt_q,
  input  logic [N_CMP*CNT_W-1:0] buf_flat,
  output logic [N_CMP-2:0]       pulse_o
);
  logic running;
  assign running = (st_q == ST_RUN);

  for (genvar k = 1; k < N_CMP; k++) begin : g_out
    assign pulse_o[k-1] = running && (cnt_q < buf_flat[k*CNT_W +: CNT_W]);
  end
endmodule

// File: rtl/trig_pulse_timer.sv
module trig_pulse_timer
  import tpt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int N_CMP  = 4,
  parameter int N_SRC  = 8,
  parameter int ADDR_W = 3,
  localparam int SEL_W = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              trig_i,
  input  logic [N_SRC-1:0]  tick_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [N_CMP-2:0]  pulse_o
);
  tpt_state_e             st_q;
  logic                   tick_sel;
  logic                   trig_edge;
  logic                   start;
  logic                   stop_w;
  logic                   load_all;
  logic                   clr_ev;
  logic                   arm_q;
  logic                   wr_arm;
  logic                   run_w;
  logic [N_CMP*CNT_W-1:0] buf_flat;
  logic [CNT_W-1:0]       buf0_w;

  assign run_w  = (st_q == ST_RUN);
  assign buf0_w = buf_flat[CNT_W-1:0];

  tpt_ctrl #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_ctrl_bits(wr_data[SEL_W:0]), .trig_i(trig_i), .tick_i(tick_i),
    .st_q(st_q), .tick_sel(tick_sel), .trig_edge(trig_edge),
    .start(start), .stop(stop_w), .load_all(load_all)
  );

  tpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .st_q(st_q), .start(start), .stop(stop_w),
    .trig_edge(trig_edge), .tick_sel(tick_sel), .period_buf(buf0_w),
    .cnt_q(count_o), .clr_ev(clr_ev)
  );

  tpt_cmpbuf #(.CNT_W(CNT_W), .N_CMP(N_CMP), .ADDR_W(ADDR_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load_all(load_all), .clr_ev(clr_ev),
    .buf_flat(buf_flat), .arm_q(arm_q), .wr_arm(wr_arm)
  );

  tpt_outgen #(.CNT_W(CNT_W), .N_CMP(N_CMP)) u_out (
    .st_q(st_q), .cnt_q(count_o), .buf_flat(buf_flat), .pulse_o(pulse_o)
  );
endmodule

// File: rtl/tpt_checker.sv
module tpt_checker #(
  parameter int CNT_W = 16,
  parameter int N_CMP = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   run_w,
  input logic                   stop_w,
  input logic                   clr_ev,
  input logic                   load_all,
  input logic                   trig_edge,
  input logic                   tick_sel,
  input logic                   arm_q,
  input logic                   wr_arm,
  input logic [CNT_W-1:0]       count_o,
  input logic [CNT_W-1:0]       buf0_w,
  input logic [N_CMP*CNT_W-1:0] buf_flat,
  input logic [N_CMP-2:0]       pulse_o
);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_w |-> (count_o == '0 && pulse_o == '0));

  assert_stop_halts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_w |=> !run_w);

  assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && !stop_w && !clr_ev && !tick_sel) |=> $stable(count_o));

  assert_wrap_at_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && !stop_w && tick_sel && count_o == buf0_w) |=> count_o == '0);

  assert_retrigger_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && !stop_w && trig_edge) |=> count_o == '0);

  assert_buf_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_ev && !load_all) |=> $stable(buf_flat));

  assert_arm_consumed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ev && arm_q && !wr_arm) |=> !arm_q);
endmodule

bind trig_pulse_timer tpt_checker #(.CNT_W(CNT_W), .N_CMP(N_CMP)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_w(run_w), .stop_w(stop_w), .clr_ev(clr_ev),
  .load_all(load_all), .trig_edge(trig_edge), .tick_sel(tick_sel),
  .arm_q(arm_q), .wr_arm(wr_arm), .count_o(count_o), .buf0_w(buf0_w),
  .buf_flat(buf_flat), .pulse_o(pulse_o)
);

// File: tb/tb_trig_pulse_timer.sv
`timescale 1ns/1ps
module tb_trig_pulse_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        trig = 1'b0;
  logic [7:0]  tick = '0;
  logic [15:0] count_o;
  logic [2:0]  pulse_o;

  int n_tests = 0;
  int n_fail  = 0;

  // reference state
  bit          m_en;
  int          m_sel;
  int          m_st;       // 0 idle, 1 wait, 2 run
  logic [15:0] m_cnt;
  logic [15:0] m_ccr [4];
  logic [15:0] m_buf [4];
  bit          m_arm;
  bit          m_trq;

  always #2.5 clk = ~clk;

  trig_pulse_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .trig_i(trig), .tick_i(tick),
    .count_o(count_o), .pulse_o(pulse_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_sel = 0; m_st = 0; m_cnt = '0; m_arm = 0; m_trq = 0;
      for (int i = 0; i < 4; i++) begin m_ccr[i] = '0; m_buf[i] = '0; end
    end else begin
      bit wc, stp, rise, edg, tk, st_go, runok, clr, reload;
      wc     = wr_en && wr_addr == 3'd0;
      stp    = wc && !wr_data[0];
      rise   = wc && wr_data[0] && !m_en;
      edg    = trig && !m_trq;
      tk     = tick[m_sel];
      st_go  = (m_st == 1) && edg && !stp;
      runok  = (m_st == 2) && !stp;
      clr    = st_go || (runok && edg) || (runok && tk && m_cnt == m_buf[0]);
      reload = rise || (clr && m_arm);
      if (reload) for (int i = 0; i < 4; i++) m_buf[i] = m_ccr[i];
      if (wr_en && wr_addr == 3'd5) m_arm = 1;
      else if (reload) m_arm = 0;
      if (stp || clr) m_cnt = '0;
      else if (runok && tk) m_cnt = m_cnt + 16'd1;
      if (stp) m_st = 0; else if (rise) m_st = 1; else if (st_go) m_st = 2;
      if (wc) begin m_en = wr_data[0]; m_sel = int'(wr_data[3:1]); end
      if (wr_en && wr_addr >= 3'd4) m_ccr[wr_addr - 3'd4] = wr_data;
      m_trq = trig;
    end
  end

  function automatic logic [2:0] exp_pulse();
    logic [2:0] p;
    for (int k = 1; k < 4; k++) p[k-1] = (m_st == 2) && (m_cnt < m_buf[k]);
    return p;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk(count_o == m_cnt, "R3 count vs model", count_o, m_cnt);
    chk(pulse_o == exp_pulse(), "R6 pulses vs model", pulse_o, exp_pulse());
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
  endtask

  task automatic wait_count(input int v, output bit ok);
    ok = 0;
    for (int i = 0; i < 200; i++) begin
      if (count_o == v) begin ok = 1; break; end
      step();
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #900_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    bit ok;
    void'($urandom(32'd8191));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    chk(count_o == 0 && pulse_o == 0, "R1 reset state", {pulse_o, count_o}, 0);

    tick = 8'h04;
    wr(3'd4, 16'd9); wr(3'd6, 16'd6); wr(3'd7, 16'd12); wr(3'd5, 16'd3);
    wr(3'd0, 16'd5);                         // select tick bit 2, enable
    repeat (3) step();
    chk(count_o == 0 && pulse_o == 0, "R2 trigger wait holds", {pulse_o, count_o}, 0);

    trig = 1'b1; step(); trig = 1'b0;
    chk(count_o == 0, "R3 start at zero", count_o, 0);
    chk(pulse_o == 3'b111, "R6 all high at start", pulse_o, 7);
    repeat (4) step();
    chk(count_o == 4, "R3 counts ticks", count_o, 4);
    chk(pulse_o == 3'b110, "R6 out1 low past compare", pulse_o, 6);

    tick = 8'h01;
    repeat (3) step();
    chk(count_o == 4, "R4 unselected tick ignored", count_o, 4);
    tick = 8'h04;

    wait_count(9, ok); step();
    chk(count_o == 0, "R5 wrap after compare 0", count_o, 0);

    wr(3'd6, 16'd2);
    wait_count(0, ok); wait_count(3, ok);
    chk(pulse_o == 3'b110, "R7 unarmed write not applied", pulse_o, 6);

    wr(3'd5, 16'd3);
    wait_count(0, ok); wait_count(3, ok);
    chk(pulse_o == 3'b100, "R8 armed reload applied", pulse_o, 4);

    wr(3'd4, 16'd5); wr(3'd5, 16'd3);
    wait_count(0, ok); wait_count(5, ok); step();
    chk(count_o == 0, "R8 new period after reload", count_o, 0);

    wait_count(2, ok);
    trig = 1'b1; step(); trig = 1'b0;
    chk(count_o == 0, "R9 retrigger restarts", count_o, 0);

    wr(3'd2, 16'd0); wr(3'd1, 16'd0); wr(3'd3, 16'd0);
    wait_count(4, ok);
    chk(ok, "R11 unused address ignored", ok, 1);
    chk(pulse_o == 3'b100, "R11 compares untouched", pulse_o, 4);

    wr(3'd0, 16'd4);
    chk(count_o == 0 && pulse_o == 0, "R10 stop clears", {pulse_o, count_o}, 0);
    trig = 1'b1; step(); trig = 1'b0;
    repeat (3) step();
    chk(count_o == 0, "R10 trigger ignored when off", count_o, 0);

    wr(3'd4, 16'd4); wr(3'd0, 16'd5);
    trig = 1'b1; step(); trig = 1'b0;
    wait_count(4, ok); step();
    chk(count_o == 0, "R2 enable loads compares", count_o, 0);

    for (int c = 0; c < 4000; c++) begin
      tick = 8'($urandom);
      if ($urandom % 30 == 0) trig = ~trig;
      if ($urandom % 12 == 0) begin
        int s;
        s = int'($urandom % 6);
        wr_en = 1'b1;
        if (s == 0) begin
          wr_addr = 3'd0;
          wr_data = {12'd0, 3'($urandom), 1'($urandom % 8 != 0)};
        end else if (s <= 4) begin
          wr_addr = 3'(3 + s);
          wr_data = 16'($urandom % 24);
        end else begin
          wr_addr = 3'(1 + $urandom % 3);
          wr_data = 16'($urandom);
        end
      end
      step();
    end
    summary();
  end
endmodule